// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the configuration front end of a legacy I/O controller. The host sees two byte-wide I/O locations. The first is an index port that selects a configuration register. The second, at the next address, is a data port that reads or writes the register the index points at. The whole configuration space is guarded by a key. Software must write the entry key twice in a row to the index port before any register becomes visible. Writing the exit key to the index port closes the space again.

Offsets below 0x30 form a global area shared by every logical device. That area holds the logical device number, a read-only chip identity and a small set of option bytes. Offsets from 0x30 upward are banked: each logical device owns its own copy, and the global logical device number chooses which copy the host sees. Only a limited number of devices is implemented. Each bank is a plain register file, and its first byte at 0x30 is the device enable byte. The bus is a synchronous strobe interface with one address bit, a write strobe, a read strobe and 8-bit data.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the space is locked, the index is 0x00, the logical device number is 0x00, every bank and option byte is 0x00, and `rdData` is 0xFF.
- R2: Two consecutive writes of 0x87 to the index port (`addrSel`=0) unlock the space. Reads between them do not break the sequence. A single 0x87 followed by any other write, to either port, leaves the space locked.
- R3: While the space is locked, reads of either port return 0xFF and data port writes change no register.
- R4: Writing 0xAA to the index port while unlocked locks the space and changes no register. Writing 0xAA while locked has no effect.
- R5: While unlocked, any index port write other than 0xAA stores the byte as the index, including 0x87. A read of the index port returns the stored index, and a data port (`addrSel`=1) access reaches the register at that index.
- R6: Global offset 0x07 holds the 8-bit logical device number, readable and writable through the data port.
- R7: Offsets 0x30 up to 0x30+BANK_REGS-1 are held separately for each logical device below NUM_DEVS. A write lands only in the bank of the currently selected device.
- R8: Offsets 0x22 to 0x2F are read/write option bytes that are shared by all logical devices. Every other global offset not named in R6 or R9 reads 0x00 and ignores writes.
- R9: Offset 0x20 reads 0xA2 and offset 0x21 reads 0x30 plus the 4-bit revision parameter (0x31 by default), so the upper 12 bits of the identity are 0xA23. Writes to both are ignored.
- R10: When the logical device number is NUM_DEVS or above, every offset from 0x30 up reads 0xFF and ignores writes. In an implemented bank, offsets at or above 0x30+BANK_REGS read 0x00 and ignore writes.
- R11: `rdData` is updated at the clock edge on which `rdStb` is sampled and holds its value otherwise. When a read and a write share a cycle, the read returns the state from before that write.
- R12: Offset 0x30 of each implemented bank is that device's enable byte. It resets to 0x00 and is written and read independently per device.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrSel | input | 1 | 0 selects the index port, 1 selects the data port |
| wrStb | input | 1 | Write strobe, one cycle per write |
| rdStb | input | 1 | Read strobe, one cycle per read |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, registered |

## Verification
A read strobe and a write strobe may be asserted in the same cycle, and two cases of this matter. In the first, a data port read coincides with a data port write of a new value. In the second, an index port read coincides with the exit key write. The bench raises both strobes together in each case and expects the read to return the old register value, or the old index, in that same cycle. The effect of the write is expected to show only on the following access. A behavioural model updated read-before-write is compared with `rdData` on every cycle, so any ordering slip in the key machine or the register file shows up as a mismatch.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam logic [7:0] ENTER_KEY  = 8'h87;
  localparam logic [7:0] EXIT_KEY   = 8'hAA;
  localparam logic [7:0] REG_LDN    = 8'h07;
  localparam logic [7:0] REG_ID_HI  = 8'h20;
  localparam logic [7:0] REG_ID_LO  = 8'h21;
  localparam logic [7:0] OPT_FIRST  = 8'h22;
  localparam logic [7:0] OPT_LAST   = 8'h2F;
  localparam logic [7:0] BANK_BASE  = 8'h30;
  localparam logic [7:0] IDLE_BYTE  = 8'hFF;

  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_HALF   = 2'd1,
    KEY_OPEN   = 2'd2
  } keyState_t;

  typedef struct packed {
    logic       open;
    logic       idxRd;
    logic       dataRd;
    logic       dataWr;
    logic [7:0] idx;
  } cfgStrobe_t;

endpackage

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrSel,
  input  logic       wrStb,
  input  logic       rdStb,
  input  logic [7:0] wrData,
  output cfgStrobe_t stb
);

  keyState_t  keyState, keyNext;
  logic [7:0] idxQ, idxNext;
  logic       idxWr;
  logic       dataWrRaw;
  logic       enterSeen;

  assign idxWr     = wrStb && !addrSel;
  assign dataWrRaw = wrStb && addrSel;
  assign enterSeen = idxWr && (wrData == ENTER_KEY);

  always_comb begin
    keyNext = keyState;
    idxNext = idxQ;
    unique case (keyState)
      KEY_LOCKED: begin
        if (enterSeen) keyNext = KEY_HALF;
      end
      KEY_HALF: begin
        if (enterSeen)  keyNext = KEY_OPEN;
        else if (wrStb) keyNext = KEY_LOCKED;
      end
      KEY_OPEN: begin
        if (idxWr) begin
          if (wrData == EXIT_KEY) keyNext = KEY_LOCKED;
          else                    idxNext = wrData;
        end
      end
      default: keyNext = KEY_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyState <= KEY_LOCKED;
      idxQ     <= 8'h00;
    end else begin
      keyState <= keyNext;
      idxQ     <= idxNext;
    end
  end

  always_comb begin
    stb.open   = (keyState == KEY_OPEN);
    stb.idxRd  = rdStb && !addrSel;
    stb.dataRd = rdStb && addrSel;
    stb.dataWr = dataWrRaw && (keyState == KEY_OPEN);
    stb.idx    = idxQ;
  end

  // R2: opening always follows an entry key written in the previous cycle
  a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stb.open) |-> $past(enterSeen));

  // R2: any other write while half-way leaves the space locked
  a_r2_break_relocks: assert property (@(posedge clk) disable iff (!rstN)
    (keyState == KEY_HALF && wrStb && !enterSeen) |=> !stb.open);

  // R4: exit key closes the space
  a_r4_exit_locks: assert property (@(posedge clk) disable iff (!rstN)
    (stb.open && idxWr && wrData == EXIT_KEY) |=> !stb.open);

  // R5: index only moves on an index write while unlocked
  a_r5_idx_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.open && idxWr) |=> $stable(idxQ));

endmodule

// File: rtl/sio_cfg_bank.sv
module sio_cfg_bank #(
  parameter int BANK_REGS = 16,
  localparam int OFF_W = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [OFF_W-1:0] off,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdVal
);

  logic [7:0] regs [BANK_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BANK_REGS; i++) regs[i] <= 8'h00;
    end else if (wrEn) begin
      regs[off] <= wrData;
    end
  end

  assign rdVal = regs[off];

endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter int         NUM_DEVS    = 10,
  parameter int         BANK_REGS   = 16,
  parameter logic [11:0] CHIP_FAMILY = 12'hA23,
  parameter logic [3:0]  CHIP_REV    = 4'h1
) (
  input  logic       clk,
  input  logic       rstN,
  input  cfgStrobe_t stb,
  input  logic [7:0] wrData,
  output logic [7:0] rdData
);

  localparam int          OFF_W      = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1;
  localparam int          OPT_N      = int'(OPT_LAST) - int'(OPT_FIRST) + 1;
  localparam int          OPT_W      = $clog2(OPT_N);
  localparam logic [8:0]  NUM_DEVS_W = 9'(NUM_DEVS);
  localparam logic [8:0]  BANK_LIM_W = 9'(BANK_REGS);
  localparam logic [7:0]  ID_HI      = CHIP_FAMILY[11:4];
  localparam logic [7:0]  ID_LO      = {CHIP_FAMILY[3:0], CHIP_REV};

  logic [7:0] ldnQ;
  logic [7:0] optRegs [OPT_N];
  logic [7:0] bankRd  [NUM_DEVS];
  logic [7:0] bankOff;
  logic [7:0] optOff;
  logic       bankArea;
  logic       inWindow;
  logic       devPresent;
  logic       optArea;
  logic [7:0] selBank;
  logic [7:0] readVal;

  assign bankArea   = (stb.idx >= BANK_BASE);
  assign bankOff    = stb.idx - BANK_BASE;
  assign inWindow   = ({1'b0, bankOff} < BANK_LIM_W);
  assign devPresent = ({1'b0, ldnQ} < NUM_DEVS_W);
  assign optArea    = (stb.idx >= OPT_FIRST) && (stb.idx <= OPT_LAST);
  assign optOff     = stb.idx - OPT_FIRST;

  for (genvar d = 0; d < NUM_DEVS; d++) begin : g_bank
    logic bankWr;
    assign bankWr = stb.dataWr && bankArea && inWindow && (ldnQ == 8'(d));
    sio_cfg_bank #(.BANK_REGS(BANK_REGS)) u_bank (
      .clk    (clk),
      .rstN   (rstN),
      .wrEn   (bankWr),
      .off    (bankOff[OFF_W-1:0]),
      .wrData (wrData),
      .rdVal  (bankRd[d])
    );
  end

  always_comb begin
    selBank = 8'h00;
    for (int d = 0; d < NUM_DEVS; d++) begin
      if (ldnQ == 8'(d)) selBank = bankRd[d];
    end
  end

  always_comb begin
    if (bankArea) begin
      if (!devPresent)    readVal = IDLE_BYTE;
      else if (!inWindow) readVal = 8'h00;
      else                readVal = selBank;
    end else if (optArea) begin
      readVal = optRegs[optOff[OPT_W-1:0]];
    end else begin
      unique case (stb.idx)
        REG_LDN:   readVal = ldnQ;
        REG_ID_HI: readVal = ID_HI;
        REG_ID_LO: readVal = ID_LO;
        default:   readVal = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldnQ <= 8'h00;
      for (int i = 0; i < OPT_N; i++) optRegs[i] <= 8'h00;
    end else if (stb.dataWr) begin
      if (stb.idx == REG_LDN) ldnQ <= wrData;
      if (optArea) optRegs[optOff[OPT_W-1:0]] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= IDLE_BYTE;
    end else if (stb.idxRd) begin
      rdData <= stb.open ? stb.idx : IDLE_BYTE;
    end else if (stb.dataRd) begin
      rdData <= stb.open ? readVal : IDLE_BYTE;
    end
  end

  // R3: reads while locked return the idle byte
  a_r3_locked_read: assert property (@(posedge clk) disable iff (!rstN)
    ((stb.dataRd || stb.idxRd) && !stb.open) |=> (rdData == IDLE_BYTE));

  // R6: device number only changes on a data write to its offset
  a_r6_ldn_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.dataWr && stb.idx == REG_LDN) |=> $stable(ldnQ));

  // R9: identity high byte reads the family value
  a_r9_id_high: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dataRd && stb.open && stb.idx == REG_ID_HI) |=> (rdData == ID_HI));

  // R10: banked offsets of an absent device read the idle byte
  a_r10_absent_bank: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dataRd && stb.open && bankArea && !devPresent) |=> (rdData == IDLE_BYTE));

  // R11: read data holds without a read strobe
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.dataRd || stb.idxRd) |=> $stable(rdData));

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          NUM_DEVS    = 10,
  parameter int          BANK_REGS   = 16,
  parameter logic [11:0] CHIP_FAMILY = 12'hA23,
  parameter logic [3:0]  CHIP_REV    = 4'h1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrSel,
  input  logic       wrStb,
  input  logic       rdStb,
  input  logic [7:0] wrData,
  output logic [7:0] rdData
);

  cfgStrobe_t stb;

  sio_cfg_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .addrSel (addrSel),
    .wrStb   (wrStb),
    .rdStb   (rdStb),
    .wrData  (wrData),
    .stb     (stb)
  );

  sio_cfg_regs #(
    .NUM_DEVS    (NUM_DEVS),
    .BANK_REGS   (BANK_REGS),
    .CHIP_FAMILY (CHIP_FAMILY),
    .CHIP_REV    (CHIP_REV)
  ) u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (wrData),
    .rdData (rdData)
  );

endmodule

// File: tb/sio_cfg_port_bench.sv
module sio_cfg_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NDEV = 10;
  localparam int NREG = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       addrSel = 1'b0;
  logic       wrStb = 1'b0;
  logic       rdStb = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sio_cfg_port u_sio_cfg_port (
    .clk(clk), .rstN(rstN), .addrSel(addrSel), .wrStb(wrStb),
    .rdStb(rdStb), .wrData(wrData), .rdData(rdData)
  );

  // behavioural reference: 0 locked, 1 one key seen, 2 open
  int mState, mIdx, mLdn, mRd;
  int mGlob [256];
  int mBank [NDEV][256];

  function automatic int mRead();
    if (mState != 2) return 255;
    if (mIdx >= 48) begin
      if (mLdn >= NDEV) return 255;
      if (mIdx - 48 >= NREG) return 0;
      return mBank[mLdn][mIdx];
    end
    if (mIdx == 7) return mLdn;
    if (mIdx == 32) return 'hA2;
    if (mIdx == 33) return 'h31;
    if (mIdx >= 34 && mIdx <= 47) return mGlob[mIdx];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mIdx = 0; mLdn = 0; mRd = 255;
      for (int i = 0; i < 256; i++) begin
        mGlob[i] = 0;
        for (int d = 0; d < NDEV; d++) mBank[d][i] = 0;
      end
    end else begin
      if (rdStb) mRd = addrSel ? mRead() : ((mState == 2) ? mIdx : 255);
      if (wrStb && !addrSel) begin
        if (mState == 0) begin
          if (wrData == 8'h87) mState = 1;
        end else if (mState == 1) begin
          mState = (wrData == 8'h87) ? 2 : 0;
        end else begin
          if (wrData == 8'hAA) mState = 0;
          else mIdx = int'(wrData);
        end
      end else if (wrStb && addrSel) begin
        if (mState == 1) mState = 0;
        else if (mState == 2) begin
          if (mIdx == 7) mLdn = int'(wrData);
          else if (mIdx >= 34 && mIdx <= 47) mGlob[mIdx] = int'(wrData);
          else if (mIdx >= 48 && mLdn < NDEV && mIdx - 48 < NREG)
            mBank[mLdn][mIdx] = int'(wrData);
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // R11: per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) chk("R11 model", int'(rdData), mRd);
  end

  task automatic op(input logic a, input logic w, input logic r, input logic [7:0] d);
    addrSel = a; wrStb = w; rdStb = r; wrData = d;
    @(negedge clk);
    wrStb = 1'b0; rdStb = 1'b0;
  endtask

  task automatic wrI(input logic [7:0] d); op(1'b0, 1'b1, 1'b0, d); endtask
  task automatic wrD(input logic [7:0] d); op(1'b1, 1'b1, 1'b0, d); endtask
  task automatic rdD(input string tag, input int exp);
    op(1'b1, 1'b0, 1'b1, 8'h00); chk(tag, int'(rdData), exp);
  endtask
  task automatic rdI(input string tag, input int exp);
    op(1'b0, 1'b0, 1'b1, 8'h00); chk(tag, int'(rdData), exp);
  endtask
  task automatic unlock(); wrI(8'h87); wrI(8'h87); endtask
  task automatic setReg(input logic [7:0] r, input logic [7:0] d); wrI(r); wrD(d); endtask
  task automatic getReg(input string tag, input logic [7:0] r, input int exp);
    wrI(r); rdD(tag, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset rdData", int'(rdData), 'hFF);
    rdD("R3 locked data read", 'hFF);
    rdI("R3 locked index read", 'hFF);
    setReg(8'h07, 8'h05);                 // ignored while locked (R3)
    unlock();
    rdI("R1 reset index", 'h00);
    getReg("R3 locked write ignored", 8'h07, 'h00);
    getReg("R9 id high", 8'h20, 'hA2);
    getReg("R9 id low", 8'h21, 'h31);
    wrD(8'h00);
    rdD("R9 id write ignored", 'h31);

    // R2: broken sequences
    wrI(8'hAA);
    wrI(8'h87); wrD(8'h11); wrI(8'h87);
    rdD("R2 data write breaks key", 'hFF);
    wrI(8'h21);                           // breaks again
    wrI(8'h87); wrI(8'h20); wrI(8'h87);
    rdI("R2 index write breaks key", 'hFF);
    wrI(8'h21);
    wrI(8'h87); rdD("R2 read between keys", 'hFF); wrI(8'h87);
    rdI("R2 unlocked after read gap", 'h21);

    // R5, R6
    wrI(8'h87);
    rdI("R5 entry key stored as index", 'h87);
    setReg(8'h07, 8'h03);
    getReg("R6 device number", 8'h07, 'h03);

    // R7, R12 banks
    setReg(8'h30, 8'h5A);
    setReg(8'h35, 8'h77);
    setReg(8'h07, 8'h04);
    getReg("R12 other bank enable reset", 8'h30, 'h00);
    setReg(8'h30, 8'hC3);
    getReg("R7 other bank offset", 8'h35, 'h00);
    setReg(8'h07, 8'h03);
    getReg("R12 bank 3 enable", 8'h30, 'h5A);
    getReg("R7 bank 3 offset", 8'h35, 'h77);
    setReg(8'h07, 8'h04);
    getReg("R12 bank 4 enable", 8'h30, 'hC3);

    // R10
    setReg(8'h40, 8'h66);
    rdD("R10 beyond window", 'h00);
    setReg(8'h07, 8'h09);
    getReg("R10 last bank present", 8'h30, 'h00);
    setReg(8'h07, 8'h0A);
    getReg("R10 absent bank", 8'h30, 'hFF);
    setReg(8'h07, 8'hF0);
    setReg(8'h30, 8'h12);
    rdD("R10 absent bank write", 'hFF);

    // R8 shared globals
    setReg(8'h25, 8'h99);
    setReg(8'h07, 8'h03);
    getReg("R8 option shared", 8'h25, 'h99);
    getReg("R10 bank 3 kept", 8'h30, 'h5A);
    setReg(8'h10, 8'h44);
    rdD("R8 unused global", 'h00);
    setReg(8'h2F, 8'hE1);
    getReg("R8 last option", 8'h2F, 'hE1);

    // R11 same-cycle read and write
    wrI(8'h25);
    op(1'b1, 1'b1, 1'b1, 8'h11);
    chk("R11 read before write", int'(rdData), 'h99);
    rdD("R11 write landed", 'h11);
    op(1'b0, 1'b1, 1'b1, 8'hAA);
    chk("R11 index read with exit", int'(rdData), 'h25);

    // R4
    rdD("R4 locked after exit", 'hFF);
    wrD(8'h00);
    wrI(8'hAA);
    unlock();
    rdI("R4 index kept", 'h25);
    rdD("R4 option kept", 'h11);

    // reset mid-run returns to R1 state
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    rdD("R1 locked after reset", 'hFF);
    unlock();
    getReg("R1 device number reset", 8'h07, 'h00);
    getReg("R1 bank reset", 8'h30, 'h00);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule